// File: doc/BRIEF.md
# Half-Duplex Serial Link With High-Level Framing

This block sends and receives bytes over a two-wire, half-duplex differential pair. The framing differs from the usual asynchronous serial convention: both the start bit and the stop bit are logic 1, and the pair is left undriven between frames. Because an undriven pair reads as 0, a receiver recognises a new frame by a high level on the line, not by a falling edge.

The transmit half takes a byte and a one-cycle start strobe. It drives ten bit periods onto the line: start, eight data bits least significant first, then stop. While it does so it raises a driver-enable for the external line driver. The receive half synchronises the line input and waits for a high level. It confirms the start bit half a bit period later and samples each data bit at its centre. It then checks the stop bit and presents the byte with a one-cycle valid pulse and a framing-error flag. The bit period in clock cycles is derived from the system clock and bit-rate parameters (9600 baud by default). The two halves share one pair, so each locks the other out.

Top module: `hdx_link`

## Requirements
- R1: While reset is held low and in the first cycle after it, line_oe, line_out, tx_busy, tx_done, rx_valid and rx_ferr are all 0.
- R2: An accepted tx_go sends ten bit periods of BIT_CYC cycles each. Period 0 is 1 (start), periods 1 to 8 carry tx_byte bits 0 to 7 in that order, and period 9 is 1 (stop).
- R3: line_oe rises in the cycle after an accepted tx_go and stays high for exactly 10*BIT_CYC cycles. line_out is 0 whenever line_oe is 0.
- R4: tx_busy is high in exactly the cycles where line_oe is high. tx_done is a one-cycle pulse in the first cycle after line_oe falls.
- R5: tx_go is ignored while a transmission is in progress and while the receiver is inside a frame. The byte and the frame length on the line do not change, and line_oe stays 0 during a received frame.
- R6: The receiver starts a frame on a high level of the synchronised line. It confirms the start bit half a bit period later. A high pulse shorter than that is discarded and gives no rx_valid.
- R7: rx_byte takes the eight data bits in arrival order as bits 0 to 7. rx_valid is a one-cycle pulse appearing 3 + BIT_CYC/2 + 9*BIT_CYC cycles after the line first goes high.
- R8: rx_ferr is updated with each rx_valid. It is 1 when the stop bit was sampled as 0 and 0 when it was sampled as 1.
- R9: After a frame whose stop bit was 1, the receiver waits for the line to return low before it looks for a new start. A line held high after the stop bit gives no second frame.
- R10: While tx_busy is high the receiver ignores the line, so the block's own transmission echoed back gives no rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_byte | input | 8 | Byte to send, captured on an accepted tx_go |
| tx_go | input | 1 | One-cycle request to send tx_byte |
| line_in | input | 1 | Received line level (undriven pair reads 0) |
| line_out | output | 1 | Transmit data to the line driver |
| line_oe | output | 1 | Line driver enable, high for the whole frame |
| tx_busy | output | 1 | Transmission in progress |
| tx_done | output | 1 | One-cycle pulse after the stop bit ends |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |
| rx_ferr | output | 1 | Stop bit of the last received frame was 0 |

## Verification
On the transmit side, a tx_go sampled at one clock edge gives line_oe and the start bit right after that edge. Bit period b is centred BIT_CYC*b + BIT_CYC/2 cycles later, and tx_done appears 10*BIT_CYC + 1 cycles after the strobe. The bench samples line_out at each of those centres and checks tx_done on exactly that cycle and the next. On the receive side there are two synchroniser flops and one state register between the line and the receiver, so rx_valid is due 3 + BIT_CYC/2 + 9*BIT_CYC cycles after the bench raises the line. The bench drives the line one bit at a time on falling edges. It counts those edges and checks that rx_valid is low one cycle before the due cycle and high on it. Every sample is taken on a falling clock edge.

// File: rtl/hdx_pkg.sv
// Shared constants and types for the half-duplex high-level-framed link.
package hdx_pkg;
    localparam int FRAME_BITS = 10;   // start + 8 data + stop
    localparam int DATA_BITS  = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITLOW
    } rx_state_t;
endpackage

// File: rtl/hdx_bitclk.sv
// Bit-period timer. While run is high it counts BIT_CYC cycles per period.
// It flags the centre (mid) and the last cycle (last) of each period.
// Assumes BIT_CYC >= 4. The count restarts from zero whenever run is low.
module hdx_bitclk #(
    parameter int BIT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mid,
    output logic last
);
    localparam int CW = $clog2(BIT_CYC);
    localparam logic [CW-1:0] LAST_V = CW'(BIT_CYC - 1);
    localparam logic [CW-1:0] MID_V  = CW'(BIT_CYC / 2 - 1);

    logic [CW-1:0] cnt;

    // Purpose: cycle counter within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run)           cnt <= '0;
        else if (cnt == LAST_V)  cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign mid  = run && (cnt == MID_V);
    assign last = run && (cnt == LAST_V);
endmodule

// File: rtl/hdx_tx.sv
// Transmit half. It loads a 10-bit frame (1, data LSB first, 1) on go and
// shifts one bit per period. It drives the line only while busy, so the pair
// is undriven when idle. Assumes go is already qualified by the caller.
module hdx_tx #(
    parameter int BIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] data,
    output logic       line_out,
    output logic       line_oe,
    output logic       busy,
    output logic       done
);
    import hdx_pkg::*;

    logic [FRAME_BITS-1:0] shreg;
    logic [3:0]            idx;
    logic                  bit_last;
    logic                  bit_mid;

    hdx_bitclk #(.BIT_CYC(BIT_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .mid  (bit_mid),
        .last (bit_last)
    );

    // Purpose: frame load, bit shifting and end-of-frame handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            shreg <= '0;
            idx   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy  <= 1'b1;
                    shreg <= {1'b1, data, 1'b1};
                    idx   <= '0;
                end
            end else if (bit_last) begin
                if (idx == 4'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    shreg <= {1'b0, shreg[FRAME_BITS-1:1]};
                    idx   <= idx + 1'b1;
                end
            end
        end
    end

    assign line_out = busy & shreg[0];
    assign line_oe  = busy;
endmodule

// File: rtl/hdx_rx.sv
// Receive half. The line passes through a two-flop synchroniser. A high level
// starts a frame, which is confirmed at mid start bit; data is sampled at
// bit centres, LSB first. After a good stop bit the receiver waits for the
// line to fall before it rearms. hold (own transmission) parks it in that wait.
module hdx_rx #(
    parameter int BIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       hold,
    output logic [7:0] byte_out,
    output logic       valid,
    output logic       ferr,
    output logic       idle
);
    import hdx_pkg::*;

    rx_state_t  state;
    logic       sync1, sync2;
    logic [7:0] shreg;
    logic [2:0] idx;
    logic       run, bit_mid, bit_last;

    // Purpose: bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= line_in;
            sync2 <= sync1;
        end
    end

    assign run  = (state == RX_START) || (state == RX_DATA) || (state == RX_STOP);
    assign idle = (state == RX_IDLE);

    hdx_bitclk #(.BIT_CYC(BIT_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .mid  (bit_mid),
        .last (bit_last)
    );

    // Purpose: frame detection, bit sampling and result presentation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            shreg    <= '0;
            idx      <= '0;
            byte_out <= '0;
            valid    <= 1'b0;
            ferr     <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (hold) begin
                state <= RX_WAITLOW;
            end else begin
                unique case (state)
                    RX_IDLE:    if (sync2) state <= RX_START;
                    RX_START:   if (bit_mid) begin
                                    state <= sync2 ? RX_DATA : RX_IDLE;
                                    idx   <= '0;
                                end
                    RX_DATA:    if (bit_mid) begin
                                    shreg <= {sync2, shreg[7:1]};
                                    idx   <= idx + 1'b1;
                                    if (idx == 3'(DATA_BITS - 1)) state <= RX_STOP;
                                end
                    RX_STOP:    if (bit_mid) begin
                                    byte_out <= shreg;
                                    valid    <= 1'b1;
                                    ferr     <= !sync2;
                                    state    <= sync2 ? RX_WAITLOW : RX_IDLE;
                                end
                    RX_WAITLOW: if (!sync2) state <= RX_IDLE;
                    default:    state <= RX_IDLE;
                endcase
            end
        end
    end

    logic unused_last;
    assign unused_last = bit_last;
endmodule

// File: rtl/hdx_link.sv
// Top of the half-duplex link. A transmit request is accepted only when the
// transmitter is free and the receiver is idle; the receiver is held off while
// the block drives the pair. Bit period = CLK_HZ / BAUD cycles (must be >= 4).
module hdx_link #(
    parameter int CLK_HZ = 200_000_000,
    parameter int BAUD   = 9600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_byte,
    input  logic       tx_go,
    input  logic       line_in,
    output logic       line_out,
    output logic       line_oe,
    output logic       tx_busy,
    output logic       tx_done,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_ferr
);
    localparam int BIT_CYC = CLK_HZ / BAUD;

    logic rx_idle;
    logic go_ok;

    assign go_ok = tx_go && rx_idle;

    hdx_tx #(.BIT_CYC(BIT_CYC)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_ok),
        .data    (tx_byte),
        .line_out(line_out),
        .line_oe (line_oe),
        .busy    (tx_busy),
        .done    (tx_done)
    );

    hdx_rx #(.BIT_CYC(BIT_CYC)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .hold    (tx_busy),
        .byte_out(rx_byte),
        .valid   (rx_valid),
        .ferr    (rx_ferr),
        .idle    (rx_idle)
    );
endmodule

// File: rtl/hdx_link_chk.sv
// Assertion checker for hdx_link, attached by bind. The frame length is
// tracked with a counter so no property depends on a large delay.
module hdx_link_chk #(
    parameter int BIT_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tx_go,
    input logic line_out,
    input logic line_oe,
    input logic tx_busy,
    input logic tx_done,
    input logic rx_valid
);
    localparam int FRAME_CYC = 10 * BIT_CYC;
    localparam int KW = $clog2(FRAME_CYC + 2);

    logic [KW-1:0] oe_cnt;

    // Purpose: count cycles of the current driver-enable window.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_cnt <= '0;
        else if (line_oe) oe_cnt <= oe_cnt + 1'b1;
        else              oe_cnt <= '0;
    end

    p_undriven_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> !line_out);
    p_frame_len_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> oe_cnt < KW'(FRAME_CYC));
    p_frame_len_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && oe_cnt == KW'(FRAME_CYC - 1)) |=> !line_oe);
    p_oe_needs_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_oe ##1 line_oe) |-> $past(tx_go));
    p_busy_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy == line_oe);
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    p_done_after_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> tx_done);
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    p_no_rx_in_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_valid);
endmodule

bind hdx_link hdx_link_chk #(.BIT_CYC(BIT_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_go   (tx_go),
    .line_out(line_out),
    .line_oe (line_oe),
    .tx_busy (tx_busy),
    .tx_done (tx_done),
    .rx_valid(rx_valid)
);

// File: tb/sim_hdx_link.sv
// Directed bench for hdx_link: one task per scenario, each checking itself.
module sim_hdx_link;
    localparam int CLK_HZ = 160_000;
    localparam int BAUD   = 10_000;
    localparam int N      = CLK_HZ / BAUD;       // 16 cycles per bit
    localparam int DUE    = 3 + N / 2 + 9 * N;   // rx_valid offset from line rise

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_go = 1'b0;
    logic       drv = 1'b0;
    logic       echo = 1'b0;
    logic       line_in;
    logic       line_out, line_oe, tx_busy, tx_done, rx_valid, rx_ferr;
    logic [7:0] rx_byte;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    always_comb line_in = echo ? (line_oe & line_out) : drv;

    hdx_link #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_go(tx_go),
        .line_in(line_in), .line_out(line_out), .line_oe(line_oe),
        .tx_busy(tx_busy), .tx_done(tx_done), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // R1: reset values during and right after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 during reset", {line_oe, line_out, tx_busy, tx_done, rx_valid, rx_ferr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {line_oe, line_out, tx_busy, tx_done, rx_valid, rx_ferr}, 0);
    endtask

    // R2/R3/R4 (and R5 when regrab, R10 when loop): send one byte, check it.
    task automatic t_send(logic [7:0] d, bit regrab, bit loop);
        int nvalid = 0;
        echo = loop;
        @(negedge clk); tx_byte = d; tx_go = 1'b1;
        @(negedge clk); tx_go = 1'b0;
        check("R3 oe rises", line_oe, 1);
        check("R4 busy", tx_busy, 1);
        repeat (N / 2 - 1) @(negedge clk);
        for (int b = 0; b < 10; b++) begin
            logic e;
            e = (b == 0 || b == 9) ? 1'b1 : d[b-1];
            check("R2 bit value", line_out, e);
            check("R3 oe held", line_oe, 1);
            if (b < 9) begin
                if (regrab && b == 4) begin
                    tx_byte = ~d; tx_go = 1'b1;
                    @(negedge clk); tx_go = 1'b0;
                    if (rx_valid) nvalid++;
                    repeat (N - 1) begin @(negedge clk); if (rx_valid) nvalid++; end
                end else begin
                    repeat (N) begin @(negedge clk); if (rx_valid) nvalid++; end
                end
            end
        end
        repeat (N / 2) begin @(negedge clk); if (rx_valid) nvalid++; end
        check("R3 last cycle oe", line_oe, 1);
        check("R4 no early done", tx_done, 0);
        @(negedge clk);
        check("R3 oe falls", line_oe, 0);
        check("R3 undriven low", line_out, 0);
        check("R4 done pulse", tx_done, 1);
        check("R4 busy clear", tx_busy, 0);
        if (regrab) check("R5 no restart", line_oe, 0);
        @(negedge clk);
        check("R4 done one cycle", tx_done, 0);
        if (loop) check("R10 no rx during tx", nvalid, 0);
        echo = 1'b0;
        repeat (6) @(negedge clk);
        if (loop) check("R10 no rx after tx", rx_valid, 0);
    endtask

    // R6/R7/R8/R9 (R5 when go_at >= 0): drive one frame onto the line.
    task automatic t_recv(logic [7:0] d, logic stopv, int extra_hi, int go_at);
        int nvalid = 0;
        for (int k = 0; k < 10 * N + extra_hi; k++) begin
            int b;
            b = k / N;
            if (b == 0)      drv = 1'b1;
            else if (b < 9)  drv = d[b-1];
            else if (b == 9) drv = stopv;
            else             drv = 1'b1;
            tx_go = (k == go_at);
            if (k == DUE - 1) check("R7 not early", rx_valid, 0);
            if (k == DUE) begin
                check("R7 valid due", rx_valid, 1);
                check("R7 byte", rx_byte, d);
                check("R8 ferr", rx_ferr, !stopv);
            end
            if (k == DUE + 1) check("R7 one cycle", rx_valid, 0);
            if (rx_valid) nvalid++;
            if (go_at >= 0 && k > go_at) check("R5 oe stays low", line_oe, 0);
            @(negedge clk);
        end
        tx_go = 1'b0;
        drv = 1'b0;
        repeat (2 * N) begin if (rx_valid) nvalid++; @(negedge clk); end
        check("R9 single frame", nvalid, 1);
    endtask

    // R6: short high pulse is discarded.
    task automatic t_glitch();
        int nvalid = 0;
        drv = 1'b1;
        repeat (3) @(negedge clk);
        drv = 1'b0;
        repeat (12 * N) begin @(negedge clk); if (rx_valid) nvalid++; end
        check("R6 glitch rejected", nvalid, 0);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_send(8'hA5, 1'b0, 1'b0);
        t_send(8'h01, 1'b0, 1'b0);
        t_send(8'h3C, 1'b1, 1'b0);
        t_send(8'hFF, 1'b0, 1'b1);
        t_recv(8'h5A, 1'b1, 0, -1);
        t_recv(8'h80, 1'b0, 0, -1);
        t_recv(8'hC3, 1'b1, 2 * N, 40);
        t_glitch();
        t_recv(8'h00, 1'b1, 0, -1);
        t_send(8'h96, 1'b0, 1'b0);
        summary();
    end
endmodule